// File: doc/BRIEF.md
# Protected Nonvolatile Byte Write Controller

This block is the register front end for a small byte-wide nonvolatile store on a CPU I/O bus. Software loads an address register and a data register, then starts either a read or a programming cycle through a four-bit control register. Programming is guarded by a two-step unlock. An unlock bit must be set first, and it expires by itself after a short window. The programming strobe only takes effect while that bit is still set.

The programming time is measured in pulses from a separate slow timing oscillator. Each pulse arrives as a one-cycle strobe already synchronised to the system clock. While a programming cycle runs, the busy bit reads back as one. Software polls this bit, or relies on a ready interrupt that is asserted whenever the store is idle and the interrupt is enabled. Each accepted strobe holds the CPU for a fixed number of cycles. If software rewrites the address or data register during programming, the cycle is aborted and nothing is stored.

Top module: `nvm_write_ctrl`

## Requirements
- R1: After reset the control readback `ctrl_rd` is zero. Bits 7 to 4 of `ctrl_rd` always read as zero. Control bit layout: bit 3 ready-interrupt enable, bit 2 unlock, bit 1 program (busy), bit 0 fetch.
- R2: A control write (`reg_sel`=0) sets the unlock bit only when the written data has bit 2 at one and bit 1 at zero.
- R3: Once set, the unlock bit reads one for exactly UNLOCK_WIN (4) cycles and then clears without any software action.
- R4: A control write with bit 1 at one starts programming only while the unlock bit is set and no programming is in progress. Otherwise it has no effect: the busy bit stays zero, no stall is raised and the store is unchanged.
- R5: The busy bit stays one until PROG_TICKS pulses of `prog_tick` have been counted after the start. It clears on the edge of the last pulse, and the data register byte is then stored at the address register location.
- R6: An accepted programming start raises `cpu_stall` for WR_STALL (2) cycles. An accepted fetch raises it for RD_STALL (4) cycles.
- R7: A control write with bit 0 at one, made while idle, sets the fetch bit for two cycles. When the fetch bit clears, `data_rd` holds the stored byte at the current address.
- R8: `ready_irq` equals, one cycle late, the AND of ready-interrupt enable, `global_ie` and NOT busy.
- R9: Writing the address register (`reg_sel`=1) or the data register (`reg_sel`=2) while busy clears busy on that edge, and the old stored byte is kept.
- R10: A fetch request made while busy is ignored: the fetch bit stays zero and `data_rd` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| reg_wdata | input | DATA_W | Register write data |
| global_ie | input | 1 | CPU global interrupt enable |
| prog_tick | input | 1 | One-cycle pulse from the slow timing oscillator |
| ctrl_rd | output | 8 | Control register readback |
| addr_rd | output | ADDR_W | Address register readback |
| data_rd | output | DATA_W | Data register readback |
| cpu_stall | output | 1 | CPU hold request |
| ready_irq | output | 1 | Ready interrupt request |

## Verification
The assertions check several rules on every cycle. Busy can only rise while the unlock bit is set, and it rises together with the stall. It falls only on an oscillator pulse or an abort. A rewrite of the address or data register during programming always drops busy, and the ready interrupt is never asserted in a settled busy cycle. Other behaviour needs the bench's scenarios, because it depends on stored contents and exact cycle counts. These scenarios cover the exact expiry of the unlock window and the stall lengths. They also include a sweep that programs every location and reads it back. Finally, they read back locations after refused or aborted writes to show that the old bytes survived.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int BIT_FETCH  = 0;
  localparam int BIT_PROG   = 1;
  localparam int BIT_UNLOCK = 2;
  localparam int BIT_IRQEN  = 3;
endpackage

// File: rtl/nvm_unlock_timer.sv
module nvm_unlock_timer #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic unlock
);
  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock <= 1'b0;
      cnt    <= '0;
    end else if (arm) begin
      unlock <= 1'b1;
      cnt    <= CW'(WIN);
    end else if (unlock) begin
      if (cnt == CW'(1)) unlock <= 1'b0;
      cnt <= cnt - CW'(1);
    end
  end

  // R3: a freshly opened window never closes on the next edge
  assert_unlock_hold_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |=> unlock);
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int TICKS = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic tick,
  output logic done
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  logic [CW-1:0] cnt;

  assign done = busy && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !busy) cnt <= '0;
    else if (tick)    cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
  parameter int WCYC = 2,
  parameter int RCYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load_w,
  input  logic load_r,
  output logic stall
);
  localparam int MAXC = (WCYC > RCYC) ? WCYC : RCYC;
  localparam int SW   = $clog2(MAXC + 1);
  logic [SW-1:0] cnt;

  assign stall = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load_w)       cnt <= SW'(WCYC);
    else if (load_r)       cnt <= SW'(RCYC);
    else if (cnt != '0)    cnt <= cnt - SW'(1);
  end
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int PROG_TICKS = 2048,
  parameter int UNLOCK_WIN = 4,
  parameter int WR_STALL   = 2,
  parameter int RD_STALL   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              global_ie,
  input  logic              prog_tick,
  output logic [7:0]        ctrl_rd,
  output logic [ADDR_W-1:0] addr_rd,
  output logic [DATA_W-1:0] data_rd,
  output logic              cpu_stall,
  output logic              ready_irq
);
  initial assert (ADDR_W <= DATA_W && DATA_W >= 4);

  reg_sel_e sel;
  logic wr_ctrl, wr_addr, wr_data;
  logic arm, start, rd_req, abort, done, mem_we;
  logic unlock, busy, fetch, fetch_late, irq_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, rd_q;

  assign sel     = reg_sel_e'(reg_sel);
  assign wr_ctrl = reg_wr && (sel == SEL_CTRL);
  assign wr_addr = reg_wr && (sel == SEL_ADDR);
  assign wr_data = reg_wr && (sel == SEL_DATA);

  assign arm    = wr_ctrl && reg_wdata[BIT_UNLOCK] && !reg_wdata[BIT_PROG];
  assign start  = wr_ctrl && reg_wdata[BIT_PROG] && unlock && !busy;
  assign rd_req = wr_ctrl && reg_wdata[BIT_FETCH] && !busy && !start;
  assign abort  = busy && (wr_addr || wr_data);
  assign mem_we = done && !abort;

  nvm_unlock_timer #(.WIN(UNLOCK_WIN)) u_unlock (
    .clk(clk), .rst(rst), .arm(arm), .unlock(unlock));

  nvm_prog_timer #(.TICKS(PROG_TICKS)) u_prog (
    .clk(clk), .rst(rst), .busy(busy), .tick(prog_tick), .done(done));

  nvm_stall_gen #(.WCYC(WR_STALL), .RCYC(RD_STALL)) u_stall (
    .clk(clk), .rst(rst), .load_w(start), .load_r(rd_req), .stall(cpu_stall));

  nvm_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk(clk), .we(mem_we), .addr(addr_q), .wdata(data_q), .rdata(rd_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en     <= 1'b0;
      busy       <= 1'b0;
      fetch      <= 1'b0;
      fetch_late <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
      ready_irq  <= 1'b0;
    end else begin
      if (wr_ctrl) irq_en <= reg_wdata[BIT_IRQEN];
      if (wr_addr) addr_q <= reg_wdata[ADDR_W-1:0];

      if (start)               busy <= 1'b1;
      else if (abort || done)  busy <= 1'b0;

      if (rd_req) begin
        fetch      <= 1'b1;
        fetch_late <= 1'b0;
      end else if (fetch && !fetch_late) begin
        fetch_late <= 1'b1;
      end else if (fetch_late) begin
        fetch      <= 1'b0;
        fetch_late <= 1'b0;
      end

      if (fetch_late)   data_q <= rd_q;
      else if (wr_data) data_q <= reg_wdata;

      ready_irq <= irq_en && global_ie && !busy;
    end
  end

  assign ctrl_rd = {4'b0000, irq_en, unlock, busy, fetch};
  assign addr_rd = addr_q;
  assign data_rd = data_q;

  assert_start_unlocked_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(unlock));
  assert_end_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(abort)) |-> $past(prog_tick));
  assert_stall_on_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> cpu_stall);
  assert_stall_on_fetch_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch) |-> cpu_stall);
  assert_fetch_two_cycles_R7: assert property (@(posedge clk) disable iff (rst)
    (fetch && $past(fetch)) |=> !fetch);
  assert_no_irq_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !ready_irq);
  assert_abort_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr && (reg_sel == 2'd1 || reg_sel == 2'd2)) |=> !busy);
  assert_fetch_refused_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr && reg_sel == 2'd0 && reg_wdata[0]) |=> !fetch);
endmodule

// File: tb/nvm_write_ctrl_bench.sv
module nvm_write_ctrl_bench;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int TK = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd3;
  logic [DW-1:0] reg_wdata = '0;
  logic global_ie = 1'b0;
  logic prog_tick = 1'b0;
  logic [7:0] ctrl_rd;
  logic [AW-1:0] addr_rd;
  logic [DW-1:0] data_rd;
  logic cpu_stall, ready_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [DW-1:0] got;

  always #10 clk = ~clk;

  nvm_write_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_TICKS(TK),
                   .UNLOCK_WIN(4), .WR_STALL(2), .RD_STALL(4)) u_nvm_write_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .global_ie(global_ie), .prog_tick(prog_tick),
    .ctrl_rd(ctrl_rd), .addr_rd(addr_rd), .data_rd(data_rd),
    .cpu_stall(cpu_stall), .ready_irq(ready_irq));

  function automatic logic [DW-1:0] pattern(input int a);
    return DW'(a * 37 + 5);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [DW-1:0] v);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      prog_tick = 1'b1; @(negedge clk);
      prog_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic start_prog(input int a, input logic [DW-1:0] d);
    wr(2'd1, DW'(a)); wr(2'd2, d); wr(2'd0, 8'h04); wr(2'd0, 8'h02);
  endtask

  task automatic read_at(input int a, output logic [DW-1:0] d);
    wr(2'd1, DW'(a)); wr(2'd0, 8'h01); idle(4);
    d = data_rd;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ctrl", ctrl_rd, 0);
    chk("R1 reset stall", cpu_stall, 0);

    // R2: unlock with bit1 also set is refused
    wr(2'd0, 8'h06);
    chk("R2 unlock refused", ctrl_rd[2], 0);
    chk("R4 no start locked", ctrl_rd[1], 0);
    // R1/R2/R3: upper bits ignored, unlock opens for exactly 4 cycles
    wr(2'd0, 8'hF4);
    chk("R1 reserved zero", ctrl_rd[7:4], 0);
    chk("R2 unlock set", ctrl_rd[2], 1);
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk);
      chk("R3 unlock window", ctrl_rd[2], (n < 4) ? 1 : 0);
    end
    // R4: strobe after expiry has no effect
    wr(2'd0, 8'h02);
    chk("R4 late strobe busy", ctrl_rd[1], 0);
    chk("R4 late strobe stall", cpu_stall, 0);

    // R5/R6: detailed program of address 0
    start_prog(0, pattern(0));
    chk("R5 busy set", ctrl_rd[1], 1);
    chk("R6 write stall c0", cpu_stall, 1);
    @(negedge clk);
    chk("R6 write stall c1", cpu_stall, 1);
    @(negedge clk);
    chk("R6 write stall end", cpu_stall, 0);
    ticks(TK - 1);
    chk("R5 busy before last tick", ctrl_rd[1], 1);
    ticks(1);
    chk("R5 busy after last tick", ctrl_rd[1], 0);

    // sweep: program the rest
    for (int a = 1; a < (1 << AW); a++) begin
      start_prog(a, pattern(a));
      ticks(TK);
    end

    // R6/R7: detailed fetch of address 5
    wr(2'd1, DW'(5)); wr(2'd0, 8'h01);
    chk("R7 fetch set", ctrl_rd[0], 1);
    chk("R6 read stall c0", cpu_stall, 1);
    @(negedge clk);
    chk("R7 fetch c1", ctrl_rd[0], 1);
    @(negedge clk);
    chk("R7 fetch clear", ctrl_rd[0], 0);
    chk("R7 fetch data", data_rd, pattern(5));
    chk("R6 read stall c2", cpu_stall, 1);
    @(negedge clk);
    chk("R6 read stall c3", cpu_stall, 1);
    @(negedge clk);
    chk("R6 read stall end", cpu_stall, 0);

    for (int a = 0; a < (1 << AW); a++) begin
      read_at(a, got);
      chk("R5 R7 sweep readback", got, pattern(a));
    end

    // R4: refused write leaves memory untouched
    wr(2'd1, DW'(2)); wr(2'd2, 8'hAA); wr(2'd0, 8'h02);
    ticks(TK);
    read_at(2, got);
    chk("R4 memory unchanged", got, pattern(2));

    // R9: abort by data rewrite
    start_prog(3, 8'h55);
    ticks(3);
    wr(2'd2, 8'h11);
    chk("R9 abort busy", ctrl_rd[1], 0);
    ticks(TK);
    read_at(3, got);
    chk("R9 old byte kept", got, pattern(3));
    // R9: abort by address rewrite
    start_prog(6, 8'h66);
    ticks(2);
    wr(2'd1, DW'(1));
    chk("R9 abort by addr", ctrl_rd[1], 0);
    ticks(TK);
    read_at(6, got);
    chk("R9 addr abort kept", got, pattern(6));

    // R10: fetch while busy ignored
    start_prog(4, 8'h99);
    idle(2);
    wr(2'd0, 8'h01);
    chk("R10 fetch refused", ctrl_rd[0], 0);
    chk("R10 no stall", cpu_stall, 0);
    idle(3);
    chk("R10 data kept", data_rd, 8'h99);
    ticks(TK);
    read_at(4, got);
    chk("R10 write completed", got, 8'h99);

    // R8: ready interrupt
    global_ie = 1'b1;
    wr(2'd0, 8'h08);
    idle(1);
    chk("R8 irq idle", ready_irq, 1);
    wr(2'd1, DW'(7));
    wr(2'd0, 8'h0C); wr(2'd0, 8'h0A);
    idle(1);
    chk("R8 irq busy", ready_irq, 0);
    ticks(TK);
    idle(1);
    chk("R8 irq done", ready_irq, 1);
    global_ie = 1'b0;
    idle(2);
    chk("R8 irq gie off", ready_irq, 0);
    global_ie = 1'b1;
    wr(2'd0, 8'h00);
    idle(1);
    chk("R8 irq en off", ready_irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule